// File: doc/BRIEF.md
# Credit-Based Completion Interrupt Moderator

This block decides when one descriptor ring should request a completion interrupt. It keeps a count of descriptors that hardware has completed and the driver has not yet consumed. A one-cycle strobe from the ring engine adds one to that count. A software credit-return write subtracts the number of credits being handed back. The output is a single-cycle request pulse to a message-signalled interrupt generator.

After it raises a request, the block masks itself. This mask is its own, and it has nothing to do with any per-vector mask held in the interrupt table. The driver clears the mask only by returning every outstanding credit; in that case no request is raised. If the driver returns only some of the credits, the block raises a new request at once and stays masked. Returning more credits than are outstanding clamps the count at zero and sets a sticky error flag.

Top module: `credit_irq_mod`

## Requirements
- R1: During and right after reset, `irq_o` is 0, `credits_o` is 0, `err_o` is 0 and the self-mask is clear.
- R2: A completion strobe (`cmpl_i`=1) with no credit return raises `credits_o` by one on the next clock edge.
- R3: If the self-mask is clear (outstanding count zero), a completion raises `irq_o` for exactly one cycle, starting one cycle after the strobe, and sets the self-mask.
- R4: While the self-mask is set, completions with no credit return leave `irq_o` at 0.
- R5: A credit-return write (`ret_valid_i`=1) subtracts `ret_count_i` from the outstanding count.
- R6: A credit return that brings the count to zero raises no interrupt and clears the self-mask, so the next completion raises `irq_o` again.
- R7: A credit return that leaves the count above zero raises `irq_o` for one cycle, and the self-mask stays set.
- R8: A credit return larger than the outstanding count clamps the count at 0, sets `err_o`, and is otherwise handled as a return to zero. `err_o` stays 1 until reset.
- R9: When a completion and a credit return arrive in the same cycle, the new count is old + 1 − returned. The interrupt decision follows R6/R7 on that new count.
- R10: `credits_o` always shows the current outstanding count, one cycle after the inputs that changed it.
- R11: The count saturates at 2^CNT_W − 1; further completions leave it there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmpl_i | input | 1 | One-cycle strobe: a descriptor was completed |
| ret_valid_i | input | 1 | Software credit-return write strobe |
| ret_count_i | input | CNT_W | Number of credits returned |
| irq_o | output | 1 | One-cycle interrupt request pulse |
| credits_o | output | CNT_W | Current outstanding credit count |
| err_o | output | 1 | Sticky over-return error |

## Verification
A self-mask left set with a zero count would show up at the next completion: no request pulse, one cycle after the strobe. A self-mask left clear with work outstanding would show up as an extra pulse on a completion that should have been silent. A wrong count shows on `credits_o` one cycle after the offending input. It also shifts the zero/non-zero decision on the next return, so the wrong choice between a pulse and a re-arm is visible one cycle after that write. The checks compare every output on every cycle against a reference model, including same-cycle completion and return, over-return, and saturation.

// File: rtl/credit_irq_pkg.sv
package credit_irq_pkg;
  typedef enum logic {
    MASK_OPEN = 1'b0,
    MASK_HELD = 1'b1
  } mask_state_e;
endpackage

// File: rtl/credit_cnt.sv
module credit_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmpl_i,
  input  logic             ret_valid_i,
  input  logic [CNT_W-1:0] ret_count_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_next_o,
  output logic             err_o
);
  localparam int WW = CNT_W + 2;
  localparam logic [CNT_W-1:0] MAX_CNT = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic             err_q;
  logic [WW-1:0]    wide;
  logic             under;

  always_comb begin
    wide = {2'b00, cnt_q} + WW'(cmpl_i)
         - (ret_valid_i ? {2'b00, ret_count_i} : '0);
    under = wide[WW-1];
    if (under)            cnt_next_o = '0;
    else if (wide[CNT_W]) cnt_next_o = MAX_CNT;
    else                  cnt_next_o = wide[CNT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      cnt_q <= cnt_next_o;
      if (under) err_q <= 1'b1;
    end
  end

  assign cnt_o = cnt_q;
  assign err_o = err_q;

  // R2
  cnt_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmpl_i && !ret_valid_i && cnt_q != MAX_CNT) |=> cnt_q == $past(cnt_q) + CNT_W'(1));
  // R8
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q);
  // R8
  over_ret_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_valid_i && !cmpl_i && ret_count_i > cnt_q) |=> (cnt_q == '0 && err_q));
  // R11
  sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmpl_i && !ret_valid_i && cnt_q == MAX_CNT) |=> cnt_q == MAX_CNT);
endmodule

// File: rtl/irq_decide.sv
module irq_decide
  import credit_irq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmpl_i,
  input  logic ret_valid_i,
  input  logic next_nz_i,
  output logic irq_o,
  output logic mask_o
);
  mask_state_e mask_q, mask_d;
  logic        irq_q, irq_d;

  always_comb begin
    mask_d = mask_q;
    irq_d  = 1'b0;
    if (ret_valid_i) begin
      // return decides on the resulting count
      irq_d  = next_nz_i;
      mask_d = next_nz_i ? MASK_HELD : MASK_OPEN;
    end else if (cmpl_i && mask_q == MASK_OPEN) begin
      irq_d  = 1'b1;
      mask_d = MASK_HELD;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= MASK_OPEN;
      irq_q  <= 1'b0;
    end else begin
      mask_q <= mask_d;
      irq_q  <= irq_d;
    end
  end

  assign irq_o  = irq_q;
  assign mask_o = (mask_q == MASK_HELD);

  // R3
  irq_sets_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> mask_q == MASK_HELD);
  // R4
  held_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == MASK_HELD && cmpl_i && !ret_valid_i) |=> !irq_q);
  // R3
  first_fire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == MASK_OPEN && cmpl_i && !ret_valid_i) |=> irq_q);
endmodule

// File: rtl/credit_irq_mod.sv
module credit_irq_mod #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmpl_i,
  input  logic             ret_valid_i,
  input  logic [CNT_W-1:0] ret_count_i,
  output logic             irq_o,
  output logic [CNT_W-1:0] credits_o,
  output logic             err_o
);
  logic [CNT_W-1:0] cnt_next;
  logic             mask;

  credit_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmpl_i      (cmpl_i),
    .ret_valid_i (ret_valid_i),
    .ret_count_i (ret_count_i),
    .cnt_o       (credits_o),
    .cnt_next_o  (cnt_next),
    .err_o       (err_o)
  );

  irq_decide u_dec (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmpl_i      (cmpl_i),
    .ret_valid_i (ret_valid_i),
    .next_nz_i   (cnt_next != '0),
    .irq_o       (irq_o),
    .mask_o      (mask)
  );

  // R6
  open_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mask |-> credits_o == '0);
  // R6
  zero_ret_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_valid_i && {1'b0, ret_count_i} >= {1'b0, credits_o} + (CNT_W+1)'(cmpl_i))
      |=> (!irq_o && !mask));
  // R7
  part_ret_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_valid_i && {1'b0, ret_count_i} < {1'b0, credits_o} + (CNT_W+1)'(cmpl_i))
      |=> (irq_o && mask));
endmodule

// File: tb/sim_credit_irq_mod.sv
`timescale 1ns/1ps
module sim_credit_irq_mod;
  localparam int CW = 4;
  localparam int MAXC = (1 << CW) - 1;

  typedef struct {
    logic          irq;
    logic [CW-1:0] cnt;
    logic          err;
    string         req;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmpl = 1'b0;
  logic          rv = 1'b0;
  logic [CW-1:0] rc = '0;
  logic          irq;
  logic [CW-1:0] credits;
  logic          err;

  int   total = 0;
  int   bad = 0;
  bit   done = 1'b0;
  exp_t q[$];

  int m_cnt = 0;
  bit m_mask = 1'b0;
  bit m_err = 1'b0;

  always #2.5 clk = ~clk;

  credit_irq_mod #(.CNT_W(CW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cmpl_i(cmpl), .ret_valid_i(rv),
    .ret_count_i(rc), .irq_o(irq), .credits_o(credits), .err_o(err)
  );

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(bit c, bit r, int n, string req);
    exp_t e;
    int   nx;
    bit   fire;
    @(negedge clk);
    cmpl = c; rv = r; rc = CW'(n);
    nx = m_cnt + int'(c) - (r ? n : 0);
    if (nx < 0) begin nx = 0; m_err = 1'b1; end
    if (nx > MAXC) nx = MAXC;
    fire = 1'b0;
    if (r) begin
      fire = (nx != 0);
      m_mask = (nx != 0);
    end else if (c && !m_mask) begin
      fire = 1'b1;
      m_mask = 1'b1;
    end
    m_cnt = nx;
    e.irq = fire; e.cnt = CW'(nx); e.err = m_err; e.req = req;
    q.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (rst_n && q.size() > 0) begin
        e = q.pop_front();
        chk(e.req, "irq", int'(irq), int'(e.irq));
        chk(e.req, "credits R10", int'(credits), int'(e.cnt));
        chk(e.req, "err", int'(err), int'(e.err));
      end
    end
  end

  initial begin : watchdog
    #(100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "irq", int'(irq), 0);
    chk("R1", "credits", int'(credits), 0);
    chk("R1", "err", int'(err), 0);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: self-mask clear after reset, first completion fires
    step(1, 0, 0, "R1_R3");
    step(0, 0, 0, "R3");
    step(1, 0, 0, "R4_R2");
    step(1, 0, 0, "R4");
    step(1, 0, 0, "R4");
    step(0, 1, 2, "R7_R5");
    step(1, 0, 0, "R4");
    step(0, 1, 3, "R6");
    step(0, 0, 0, "R6");
    step(1, 0, 0, "R6");
    step(1, 1, 1, "R9");
    step(1, 1, 2, "R9");
    step(1, 0, 0, "R9");
    step(1, 0, 0, "R2");
    step(0, 1, 7, "R8");
    step(0, 0, 0, "R8");
    step(1, 0, 0, "R8");
    for (int i = 0; i < 20; i++) step(1, 0, 0, "R11");
    step(1, 1, 3, "R11_R9");
    step(0, 1, MAXC, "R6");
    step(1, 1, 0, "R9");
    step(0, 0, 0, "R5");
    @(negedge clk);
    cmpl = 1'b0; rv = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule